// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block turns a flat panel's supply and control lines on and off in a fixed order, with a programmable pause between one change and the next. The pause is counted in display frames, not clock cycles. The panel timing logic supplies a one-cycle frame-start pulse, and the sequencer counts those pulses to time each step.

Software raises or lowers a single power request. The block then moves the control lines one step at a time towards the requested state. When the request changes direction partway through, the block turns round and unwinds from the step it has reached. A status flag reports whether the panel is powered. The flag changes only after a complete power-up or power-down sequence has finished. A busy output marks the time during which the lines are still moving.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is applied, all control lines are low, the status flag is 0 and busy is 0.
- R2: On power-up the lines are asserted one at a time in this order: bit 0 (panel supply), then bit 1 (data/signal enable), then bit 2 (backlight).
- R3: On power-down the lines are released one at a time in the reverse order: bit 2 first, then bit 1, then bit 0.
- R4: With a delay setting D (1 to 7), each transition comes D frame-start pulses after the previous one. The first transition comes D pulses after the request changes.
- R5: A delay setting of 0 behaves exactly like a setting of 1.
- R6: The same delay setting governs power-up and power-down alike.
- R7: The status flag goes to 1 in the cycle the last line of a power-up asserts. It goes to 0 in the cycle the last line of a power-down releases. It never changes at any other time.
- R8: A request that reverses direction mid-sequence restarts the frame count. The lines then step back from their current position, and the status flag keeps its old value until the reversed sequence completes.
- R9: Busy is 1 whenever the lines differ from the requested end state (all high when requested on, all low when requested off). Otherwise busy is 0.
- R10: Control lines change only on a clock edge that samples a frame-start pulse. Frame pulses have no effect while the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| pwr_req | input | 1 | 1 requests panel on, 0 requests panel off |
| dly_sel | input | DLY_W | Frames between transitions (0 acts as 1) |
| panel_ctl | output | N_LINES | Control lines; bit 0 is the panel supply, bit 1 is the data/signal enable, bit 2 is the backlight |
| pwr_on_sts | output | 1 | 1 when the panel is fully powered |
| seq_busy | output | 1 | 1 while a sequence is in progress |

## Verification
The assertions assume that frame_start is a single-cycle pulse. They also assume that pwr_req and dly_sel change only between edges and never on an edge that also samples a frame pulse. Under those assumptions the lines always form a thermometer code, move by at most one bit per edge, and never move on an edge that has no frame pulse. The stimulus meets the assumptions in two ways. Frame pulses come from a fixed generator, one every five cycles. Requests change only in the cycle just after a pulse has been sampled, so every expected transition lands on a whole frame count measured from the request.

// File: rtl/pps_pkg.sv
package pps_pkg;

   // Direction the line ladder is moving in.
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_dir_e;

endpackage

// File: rtl/pps_frame_timer.sv
module pps_frame_timer #(
   parameter int DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             restart,
   input  logic             frame_start,
   input  logic [DLY_W-1:0] dly,
   output logic             tick
);
   localparam int CNT_W = DLY_W + 1;

   logic [DLY_W-1:0] frame_cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] limit;

   // A zero delay field is treated as one frame.
   always_comb begin
      limit   = (dly == '0) ? CNT_W'(1) : {1'b0, dly};
      cnt_inc = {1'b0, frame_cnt} + CNT_W'(1);
   end

   assign tick = active && !restart && frame_start && (cnt_inc >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_cnt <= '0;
      end else if (restart || !active || tick) begin
         frame_cnt <= '0;
      end else if (frame_start) begin
         frame_cnt <= cnt_inc[DLY_W-1:0];
      end
   end

endmodule

// File: rtl/pps_step_ctrl.sv
module pps_step_ctrl
   import pps_pkg::*;
#(
   parameter int N_LINES = 3,
   parameter int LVL_W   = $clog2(N_LINES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  step_dir_e        dir,
   input  logic             tick,
   output logic [LVL_W-1:0] lvl
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl <= '0;
      end else if (tick) begin
         unique case (dir)
            STEP_UP:   lvl <= lvl + LVL_W'(1);
            STEP_DOWN: lvl <= lvl - LVL_W'(1);
            default:   lvl <= lvl;
         endcase
      end
   end

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
   import pps_pkg::*;
#(
   parameter int N_LINES = 3,
   parameter int DLY_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               pwr_req,
   input  logic [DLY_W-1:0]   dly_sel,
   output logic [N_LINES-1:0] panel_ctl,
   output logic               pwr_on_sts,
   output logic               seq_busy
);
   localparam int LVL_W = $clog2(N_LINES + 1);
   localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(N_LINES);

   generate
      if (N_LINES < 1 || N_LINES > 15) begin : g_bad_lines
         $error("panel_pwr_seq: N_LINES must be 1..15");
      end
      if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
         $error("panel_pwr_seq: DLY_W must be 1..16");
      end
   endgenerate

   logic [LVL_W-1:0] lvl;
   step_dir_e        dir;
   logic             req_q;
   logic             restart;
   logic             tick;

   // Direction towards the requested end state.
   always_comb begin
      if (pwr_req) dir = (lvl != LVL_FULL) ? STEP_UP : STEP_HOLD;
      else         dir = (lvl != '0)       ? STEP_DOWN : STEP_HOLD;
   end

   assign seq_busy = (dir != STEP_HOLD);
   assign restart  = (pwr_req != req_q);

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= pwr_req;
   end

   pps_frame_timer #(.DLY_W(DLY_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (seq_busy),
      .restart     (restart),
      .frame_start (frame_start),
      .dly         (dly_sel),
      .tick        (tick)
   );

   pps_step_ctrl #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_steps (
      .clk   (clk),
      .rst_n (rst_n),
      .dir   (dir),
      .tick  (tick),
      .lvl   (lvl)
   );

   // Status follows only the final step of a full sequence.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_on_sts <= 1'b0;
      end else if (tick) begin
         if (dir == STEP_UP && lvl == LVL_FULL - LVL_W'(1))
            pwr_on_sts <= 1'b1;
         else if (dir == STEP_DOWN && lvl == LVL_W'(1))
            pwr_on_sts <= 1'b0;
      end
   end

   // Line i is on once the ladder has climbed past rung i.
   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         assign panel_ctl[i] = (lvl > LVL_W'(i));
      end
   endgenerate

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
   parameter int N_LINES = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_start,
   input logic               pwr_req,
   input logic [N_LINES-1:0] panel_ctl,
   input logic               pwr_on_sts,
   input logic               seq_busy
);

   AST_THERMO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ((panel_ctl & (panel_ctl + N_LINES'(1))) == '0)); // R2 R3

   AST_ONE_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(panel_ctl ^ $past(panel_ctl)) <= 1)); // R4

   AST_FRAME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start) |-> $stable(panel_ctl)); // R10

   AST_STS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwr_on_sts) |-> (panel_ctl == '0 || panel_ctl == '1)); // R7

   AST_IDLE_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> (pwr_on_sts == (panel_ctl != '0))); // R9

   AST_REVERSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_req != $past(pwr_req)) |=> $stable(panel_ctl)); // R8

endmodule

bind panel_pwr_seq pps_checker #(.N_LINES(N_LINES)) u_pps_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .pwr_req     (pwr_req),
   .panel_ctl   (panel_ctl),
   .pwr_on_sts  (pwr_on_sts),
   .seq_busy    (seq_busy)
);

// File: tb/tb_panel_pwr_seq.sv
`timescale 1ns/1ps
module tb_panel_pwr_seq;
   localparam int N  = 3;
   localparam int DW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          frame_start;
   logic          pwr_req;
   logic [DW-1:0] dly_sel;
   logic [N-1:0]  panel_ctl;
   logic          pwr_on_sts;
   logic          seq_busy;

   always #2.5 clk = ~clk;

   panel_pwr_seq #(.N_LINES(N), .DLY_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pwr_req(pwr_req),
      .dly_sel(dly_sel), .panel_ctl(panel_ctl), .pwr_on_sts(pwr_on_sts),
      .seq_busy(seq_busy)
   );

   typedef struct {
      logic [N-1:0] ctl;
      logic         sts;
      logic         busy;
      int           frames;
      string        tag;
   } item_t;

   item_t exp_q[$];
   int    checks = 0;
   int    errors = 0;
   int    fc     = 0;
   int    base   = 0;
   bit    done   = 0;
   logic  model_sts = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Frame generator: one pulse every five cycles, driven at the falling edge.
   initial begin
      frame_start = 1'b0;
      forever begin
         repeat (4) @(negedge clk);
         frame_start = 1'b1;
         fc++;
         @(negedge clk);
         frame_start = 1'b0;
      end
   end

   // Monitor: every change of lines or status must match the next expected item.
   initial begin
      logic [N:0] prev;
      item_t      it;
      prev = '0;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && {panel_ctl, pwr_on_sts} != prev) begin
            prev = {panel_ctl, pwr_on_sts};
            if (exp_q.size() == 0) begin
               check(0, "R10", "unexpected line/status change", int'(prev), -1);
            end else begin
               it = exp_q.pop_front();
               check(panel_ctl == it.ctl, it.tag, "panel_ctl", int'(panel_ctl), int'(it.ctl));
               check(pwr_on_sts == it.sts, it.tag, "pwr_on_sts", int'(pwr_on_sts), int'(it.sts));
               check(seq_busy == it.busy, it.tag, "seq_busy", int'(seq_busy), int'(it.busy));
               check((fc - base) == it.frames, it.tag, "frames since request",
                     fc - base, it.frames);
            end
         end
      end
   end

   // Driver side of the scoreboard: queue the expected transitions.
   task automatic push_seq(input bit up, input int d, input int start_lvl,
                           input int steps, input string tag);
      int    eff;
      int    lvl;
      item_t it;
      eff = (d == 0) ? 1 : d;
      lvl = start_lvl;
      for (int k = 1; k <= steps; k++) begin
         lvl = up ? lvl + 1 : lvl - 1;
         if (lvl == N) model_sts = 1'b1;
         if (lvl == 0) model_sts = 1'b0;
         it.ctl    = N'((1 << lvl) - 1);
         it.sts    = model_sts;
         it.busy   = !((up && lvl == N) || (!up && lvl == 0));
         it.frames = k * eff;
         it.tag    = tag;
         exp_q.push_back(it);
      end
   endtask

   task automatic request(input bit up, input string tag);
      wait (frame_start == 1'b1);
      @(posedge clk);
      #1;
      pwr_req = up;
      base    = fc;
      @(posedge clk);
      #1;
      check(seq_busy == 1'b1, tag, "busy after request", int'(seq_busy), 1);
   endtask

   task automatic wait_idle(input string tag);
      wait (exp_q.size() == 0);
      @(posedge clk);
      #1;
      check(seq_busy == 1'b0, tag, "busy when complete", int'(seq_busy), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n   = 1'b0;
      pwr_req = 1'b0;
      dly_sel = '0;
      repeat (5) @(posedge clk);
      #1;
      check(panel_ctl == '0, "R1", "reset lines", int'(panel_ctl), 0);
      check(pwr_on_sts == 1'b0, "R1", "reset status", int'(pwr_on_sts), 0);
      check(seq_busy == 1'b0, "R1", "reset busy", int'(seq_busy), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R4 R7: full power-up, three frames apart
      dly_sel = 3'd3;
      push_seq(1, 3, 0, 3, "R2");
      request(1, "R9");
      wait_idle("R9");

      // R10: frame pulses while idle change nothing
      begin
         logic [N-1:0] snap;
         bit           moved;
         snap  = panel_ctl;
         moved = 0;
         repeat (30) begin
            @(posedge clk);
            #1;
            if (panel_ctl != snap || seq_busy) moved = 1;
         end
         check(!moved, "R10", "idle lines stable", int'(panel_ctl), int'(snap));
      end

      // R3 R6: power-down with the same delay
      push_seq(0, 3, N, 3, "R3");
      request(0, "R6");
      wait_idle("R6");

      // R5: zero delay acts as one frame
      dly_sel = 3'd0;
      push_seq(1, 0, 0, 3, "R5");
      request(1, "R5");
      wait_idle("R5");

      // R4: five frames between steps on power-down
      dly_sel = 3'd5;
      push_seq(0, 5, N, 3, "R4");
      request(0, "R4");
      wait_idle("R4");

      // R8: reverse a power-up after two steps
      dly_sel = 3'd2;
      push_seq(1, 2, 0, 2, "R8");
      request(1, "R8");
      wait (exp_q.size() == 0);
      push_seq(0, 2, 2, 2, "R8");
      request(0, "R8");
      wait_idle("R8");
      check(pwr_on_sts == 1'b0, "R8", "status after aborted power-up", int'(pwr_on_sts), 0);

      // R8: reverse a power-down after one step, status held at 1
      dly_sel = 3'd1;
      push_seq(1, 1, 0, 3, "R8");
      request(1, "R8");
      wait_idle("R8");
      push_seq(0, 1, N, 1, "R8");
      request(0, "R8");
      wait (exp_q.size() == 0);
      check(pwr_on_sts == 1'b1, "R8", "status held mid-reversal", int'(pwr_on_sts), 1);
      push_seq(1, 1, N - 1, 1, "R8");
      request(1, "R8");
      wait_idle("R8");

      // R4: largest delay
      dly_sel = 3'd7;
      push_seq(0, 7, N, 3, "R4");
      request(0, "R4");
      wait_idle("R4");

      check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule